// File: doc/BRIEF.md
# Keyed Linked List Search Engine

The engine walks a singly linked list held in a 16-bit word memory and stops at the first node whose key satisfies a selectable match condition. A caller supplies a head link, the offset of the key word inside each node, a search argument, a match mode, a starting value for the predecessor output and a bound on the number of nodes to visit, then pulses `start_i`. The engine issues single-word reads through a request/acknowledge master port until it reaches the end of the list, a matching node, a corrupted link or the visit bound.

On completion it pulses `done_o` and holds three results. The first is a two-bit status. The second is the address of the node where the walk stopped. The third is the address of the last node whose link was followed. Together these give a caller the insertion point for a sorted list: in greater-than mode, the predecessor and the stop node bracket the slot for a new key.

Top module: `lls_search`

## Requirements
- R1: Bit 15 of `head_i` is cleared before the walk begins, so a head of 0x8008 behaves exactly like 0x0008.
- R2: Reaching a link of 0 (including a zero head) ends the walk with status 1 (not found) and `node_o` = 0.
- R3: A link with bit 15 set ends the walk with status 0 (bad list), and `node_o` holds that link value.
- R4: The key is read from word address (node + `key_off_i`) truncated to 15 bits, and the next link from word address node; `mem_addr_o` stays stable while `mem_req_o` waits for `mem_ack_i`.
- R5: With `gt_mode_i` = 0, a node matches when its key equals `arg_i`; the walk ends with status 2 (found) and `node_o` = that node.
- R6: With `gt_mode_i` = 1, a node matches when its key is greater than `arg_i` compared as unsigned 16-bit values.
- R7: `prev_o` starts at `prev_init_i` and takes the current node address each time a link is followed, so it holds the last node left before the stop; if the head itself stops the walk, `prev_o` equals `prev_init_i`.
- R8: When `limit_i` is nonzero and that many keys have been read without a match, the walk ends with status 0 (bad list) at the next node; `limit_i` = 0 means no bound.
- R9: `busy_o` is high from the cycle after an accepted start until completion, `done_o` is a one-cycle pulse with status never 3, no request is made while idle, and `start_i` is ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a walk (accepted only when idle) |
| head_i | input | 16 | Head link |
| key_off_i | input | 16 | Word offset of the key inside a node |
| arg_i | input | 16 | Search argument |
| gt_mode_i | input | 1 | 0: equal match, 1: unsigned greater-than match |
| prev_init_i | input | 16 | Initial predecessor value |
| limit_i | input | 16 | Maximum keys read, 0 for unbounded |
| mem_req_o | output | 1 | Read request |
| mem_addr_o | output | 15 | Read word address |
| mem_ack_i | input | 1 | Read acknowledge, data valid |
| mem_rdata_i | input | 16 | Read data |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | Completion pulse |
| status_o | output | 2 | 0 bad list, 1 not found, 2 found |
| node_o | output | 16 | Stop node address |
| prev_o | output | 16 | Predecessor node address |

## Verification
The bench keeps the default 16-bit word width and a 16-bit visit counter but backs the port with a 64-word memory, so every list fits in a handful of nodes and each read outside that window returns a poison word that would show up in the results. Lists of zero to five nodes are swept against every argument in steps of five in both match modes, which reaches head stops, tail stops, misses past the end and every predecessor position. Dedicated lists cover a flagged head, a corrupted middle link, a circular list cut by the bound, a key offset that wraps past 15 bits, a key with bit 15 set in greater-than mode and a start pulse while busy.

// File: rtl/lls_pkg.sv
package lls_pkg;
  localparam int unsigned WW = 16;
  localparam int unsigned AW = WW - 1;

  typedef enum logic [1:0] {
    ST_BAD   = 2'd0,
    ST_NONE  = 2'd1,
    ST_FOUND = 2'd2
  } lls_status_e;

  typedef enum logic [1:0] {
    FS_IDLE,
    FS_CHECK,
    FS_KEY,
    FS_LINK
  } lls_fsm_e;
endpackage

// File: rtl/lls_match.sv
module lls_match #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] key_i,
  input  logic [W-1:0] arg_i,
  input  logic         gt_mode_i,
  output logic         hit_o
);
  always_comb begin
    if (gt_mode_i) hit_o = (key_i > arg_i);
    else           hit_o = (key_i == arg_i);
  end
endmodule

// File: rtl/lls_guard.sv
module lls_guard #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  input  logic [CW-1:0] limit_i,
  output logic          trip_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (clr_i)                  cnt_q <= '0;
    else if (inc_i && ~&cnt_q)       cnt_q <= cnt_q + 1'b1;
  end

  assign trip_o = (limit_i != '0) && (cnt_q >= limit_i);
endmodule

// File: rtl/lls_search.sv
module lls_search
  import lls_pkg::*;
#(
  parameter int unsigned W  = lls_pkg::WW,
  parameter int unsigned CW = 16,
  localparam int unsigned A = W - 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [W-1:0]  head_i,
  input  logic [W-1:0]  key_off_i,
  input  logic [W-1:0]  arg_i,
  input  logic          gt_mode_i,
  input  logic [W-1:0]  prev_init_i,
  input  logic [CW-1:0] limit_i,
  output logic          mem_req_o,
  output logic [A-1:0]  mem_addr_o,
  input  logic          mem_ack_i,
  input  logic [W-1:0]  mem_rdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [1:0]    status_o,
  output logic [W-1:0]  node_o,
  output logic [W-1:0]  prev_o
);
  lls_fsm_e     fsm_q;
  logic [W-1:0] cur_q, prev_q, node_q;
  logic [1:0]   stat_q;
  logic         done_q;
  logic         hit, trip;
  logic         key_ack, link_ack, accept;

  assign accept   = (fsm_q == FS_IDLE) && start_i;
  assign key_ack  = (fsm_q == FS_KEY) && mem_ack_i;
  assign link_ack = (fsm_q == FS_LINK) && mem_ack_i;

  lls_match #(.W(W)) u_match (
    .key_i    (mem_rdata_i),
    .arg_i    (arg_i),
    .gt_mode_i(gt_mode_i),
    .hit_o    (hit)
  );

  lls_guard #(.CW(CW)) u_guard (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (accept),
    .inc_i  (key_ack),
    .limit_i(limit_i),
    .trip_o (trip)
  );

  // key address wraps within the A-bit word space
  always_comb begin
    mem_req_o  = (fsm_q == FS_KEY) || (fsm_q == FS_LINK);
    mem_addr_o = cur_q[A-1:0];
    if (fsm_q == FS_KEY) mem_addr_o = cur_q[A-1:0] + key_off_i[A-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsm_q  <= FS_IDLE;
      cur_q  <= '0;
      prev_q <= '0;
      node_q <= '0;
      stat_q <= ST_NONE;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (fsm_q)
        FS_IDLE: if (start_i) begin
          cur_q  <= {1'b0, head_i[A-1:0]};
          prev_q <= prev_init_i;
          fsm_q  <= FS_CHECK;
        end
        FS_CHECK: begin
          if (cur_q == '0) begin
            node_q <= '0;
            stat_q <= ST_NONE;
            done_q <= 1'b1;
            fsm_q  <= FS_IDLE;
          end else if (cur_q[W-1] || trip) begin
            node_q <= cur_q;
            stat_q <= ST_BAD;
            done_q <= 1'b1;
            fsm_q  <= FS_IDLE;
          end else begin
            fsm_q <= FS_KEY;
          end
        end
        FS_KEY: if (mem_ack_i) begin
          if (hit) begin
            node_q <= cur_q;
            stat_q <= ST_FOUND;
            done_q <= 1'b1;
            fsm_q  <= FS_IDLE;
          end else begin
            fsm_q <= FS_LINK;
          end
        end
        FS_LINK: if (link_ack) begin
          prev_q <= cur_q;
          cur_q  <= mem_rdata_i;
          fsm_q  <= FS_CHECK;
        end
        default: fsm_q <= FS_IDLE;
      endcase
    end
  end

  assign busy_o   = (fsm_q != FS_IDLE);
  assign done_o   = done_q;
  assign status_o = stat_q;
  assign node_o   = node_q;
  assign prev_o   = prev_q;
endmodule

// File: rtl/lls_search_chk.sv
module lls_search_chk #(
  parameter int unsigned W = 16,
  localparam int unsigned A = W - 1
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic         mem_req_o,
  input logic [A-1:0] mem_addr_o,
  input logic         mem_ack_i,
  input logic         busy_o,
  input logic         done_o,
  input logic [1:0]   status_o,
  input logic [W-1:0] node_o
);
  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_status_legal_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (status_o != 2'd3));
  assert_idle_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o);
  assert_start_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
  assert_addr_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));
  assert_none_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && status_o == 2'd1) |-> (node_o == '0));
  assert_found_node_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && status_o == 2'd2) |-> (node_o != '0 && !node_o[W-1]));
endmodule

bind lls_search lls_search_chk #(.W(W)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .mem_req_o (mem_req_o),
  .mem_addr_o(mem_addr_o),
  .mem_ack_i (mem_ack_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .status_o  (status_o),
  .node_o    (node_o)
);

// File: tb/lls_search_tb.sv
module lls_search_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] head = '0, koff = '0, arg = '0, pinit = '0, limit = '0;
  logic        gtm = 1'b0;
  logic        req, ack = 1'b0;
  logic [14:0] addr;
  logic [15:0] rdata = '0;
  logic        busy, done;
  logic [1:0]  status;
  logic [15:0] node, prev;

  int total = 0, bad = 0;
  logic [15:0] mem [64];

  always #10 clk = ~clk;

  lls_search dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .head_i(head),
    .key_off_i(koff), .arg_i(arg), .gt_mode_i(gtm), .prev_init_i(pinit),
    .limit_i(limit), .mem_req_o(req), .mem_addr_o(addr), .mem_ack_i(ack),
    .mem_rdata_i(rdata), .busy_o(busy), .done_o(done), .status_o(status),
    .node_o(node), .prev_o(prev)
  );

  function automatic logic [15:0] rd(input logic [15:0] a);
    return (a < 16'd64) ? mem[a[5:0]] : 16'hDEAD;
  endfunction

  always @(posedge clk) begin
    ack   <= req && !ack;
    rdata <= rd({1'b0, addr});
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic model(output logic [1:0] es, output logic [15:0] en, output logic [15:0] ep);
    logic [15:0] cur, key;
    int v;
    cur = head & 16'h7fff; ep = pinit; v = 0; es = 2'd1; en = 16'h0;
    for (int i = 0; i < 200; i++) begin
      if (cur == 0) begin es = 2'd1; en = 16'h0; return; end
      if (cur[15] || (limit != 0 && v >= limit)) begin es = 2'd0; en = cur; return; end
      key = rd((cur + koff) & 16'h7fff);
      v++;
      if (gtm ? (key > arg) : (key == arg)) begin es = 2'd2; en = cur; return; end
      ep = cur;
      cur = rd(cur);
    end
  endtask

  task automatic run(input string tag, input bit poke);
    logic [1:0] es; logic [15:0] en, ep;
    logic [15:0] h0;
    int n;
    model(es, en, ep);
    h0 = head;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (poke) begin
      chk({tag, " R9 busy"}, {15'd0, busy}, 16'd1);
      head = 16'd0; start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    n = 0;
    while (!done && n < 1000) begin @(negedge clk); n++; end
    if (!done) begin
      total++; bad++;
      $display("FAIL %s watchdog act=busy exp=done", tag);
      return;
    end
    chk({tag, " status"}, {14'd0, status}, {14'd0, es});
    chk({tag, " node"}, node, en);
    chk({tag, " R7 prev"}, prev, ep);
    @(negedge clk);
    chk({tag, " R9 pulse"}, {14'd0, done, busy}, 16'd0);
    head = h0;
  endtask

  task automatic build(input int n);
    for (int i = 0; i < 64; i++) mem[i] = 16'hBEEF;
    for (int k = 0; k < n; k++) begin
      mem[8*k+8]  = (k == n-1) ? 16'd0 : 16'(8*k+16);
      mem[8*k+10] = 16'(10*(k+1));
    end
  endtask

  initial begin
    int wd = 0;
    fork
      begin
        repeat (3) @(negedge clk);
        chk("R9 reset", {13'd0, busy, done, req}, 16'd0);
        rst_n = 1'b1;
        koff = 16'd2; pinit = 16'h1234;
        // R5 R6 R2 R7 sweep
        for (int n = 0; n <= 5; n++) begin
          build(n);
          head = (n == 0) ? 16'd0 : 16'd8;
          for (int m = 0; m < 2; m++) begin
            gtm = m[0];
            for (int a = 0; a <= 60; a += 5) begin
              arg = 16'(a);
              run(m ? "R6 sweep" : "R5 sweep", 1'b0);
            end
          end
        end
        // R1 flagged head
        build(3); gtm = 0; arg = 16'd20; head = 16'h8008;
        run("R1 head", 1'b0);
        chk("R1 node", node, 16'd16);
        // R3 corrupted middle link
        mem[16] = 16'h8030; arg = 16'd99; head = 16'd8;
        run("R3 badlink", 1'b0);
        chk("R3 status", {14'd0, status}, 16'd0);
        // R8 circular list with bound, then unbounded on proper list
        build(3); mem[24] = 16'd8; limit = 16'd3;
        run("R8 loop", 1'b0);
        chk("R8 status", {14'd0, status}, 16'd0);
        build(5); limit = 16'd0; arg = 16'd50;
        run("R8 nolimit", 1'b0);
        limit = 16'd2;
        run("R8 cut", 1'b0);
        limit = 16'd0;
        // R4 wrapping key offset: key of node 8 at word 2
        build(2); mem[2] = 16'h0777; koff = 16'h7ffa; arg = 16'h0777;
        run("R4 wrap", 1'b0);
        chk("R4 node", node, 16'd8);
        koff = 16'd2;
        // R6 unsigned compare with bit 15 key
        build(3); mem[18] = 16'hF000; gtm = 1; arg = 16'h7000;
        run("R6 unsigned", 1'b0);
        chk("R6 node", node, 16'd16);
        // R9 start ignored while busy
        build(4); gtm = 0; arg = 16'd40;
        run("R9 ignore", 1'b1);
        chk("R9 node", node, 16'd32);
        // R2 zero head keeps prev
        head = 16'd0; pinit = 16'h0abc;
        run("R2 empty", 1'b0);
        chk("R2 prev", prev, 16'h0abc);
      end
      begin
        while (wd < 150000) begin @(posedge clk); wd++; end
        total++; bad++;
        $display("FAIL watchdog act=timeout exp=finish");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule